// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between a single bus master and the downstream memory fabric and decides, access by access, whether a read or write may pass and with which security attribute. An external region checker looks up the request address and returns two flags in the same cycle as the request: the region is exempt from checking, or the region is non-secure. The filter combines these flags with the master's configured security state. Each access then ends one of four ways. It is forwarded as secure, forwarded as non-secure, completed locally with zero data and an OK status, or completed locally with an error status.

Three single-bit configuration levels steer the filter: master-is-non-secure, error-response-enable and interrupt-clear. They are captured into registers every cycle, and a request uses the values sampled on the previous clock edge. A request to a secure region from a non-secure master that is answered with an error also raises a sticky violation flag, which drives a level interrupt. The flag is not set while interrupt-clear is held, and it is cleared whenever interrupt-clear is high. Forwarded accesses are steered onto little-endian byte lanes of the downstream data bus. The upstream port holds at most one transaction at a time.

Top module: `bus_sec_filter`

## Requirements
- R1: An exempt address is forwarded whatever the non-secure flag says. dn_req_secure is 1 when the registered master-is-non-secure level is 0, and 0 when it is 1.
- R2: A non-exempt address that the checker flags as non-secure is always forwarded with dn_req_secure = 0.
- R3: A non-exempt, secure-region access from a master configured as secure is forwarded with dn_req_secure = 1.
- R4: A non-exempt, secure-region access from a master configured as non-secure is blocked. dn_req_valid stays 0 for it, and up_rsp_valid is 1 in the cycle after the request is accepted.
- R5: A blocked access with error-response-enable at 0 completes with up_rsp_err = 0. A blocked read returns up_rsp_rdata = 0, and a blocked write never appears downstream.
- R6: A blocked access with error-response-enable at 1 completes with up_rsp_err = 1. It sets the violation flag unless the registered interrupt-clear level is 1, and irq is then 1 in the cycle after the request.
- R7: The violation flag is sticky and drives irq directly. It survives later accesses, and it reads 0 from the second cycle after interrupt-clear goes high.
- R8: After reset, irq = 0, up_req_ready = 1, dn_req_valid = 0 and up_rsp_valid = 0. The master counts as secure and error responses are disabled.
- R9: For a forwarded write, the size code k (0,1,2,3 meaning 1,2,4,8 bytes) and the offset o = addr[2:0] select byte lanes o..o+2^k-1 on dn_req_be. The low 2^k bytes of up_req_wdata appear shifted up by o bytes, and all other lanes carry zero.
- R10: For a forwarded read, up_rsp_rdata holds downstream bytes o..o+2^k-1 right-justified, with the upper bytes zero. up_rsp_err equals dn_rsp_err.
- R11: From acceptance until the response is returned, up_req_ready is 0. dn_req_valid and dn_req_addr hold steady while dn_req_ready is 0.
- R12: dn_req_valid rises in the cycle after an allowed request is accepted. up_rsp_valid is a one-cycle pulse in the cycle after dn_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_ns | input | 1 | Master is non-secure |
| cfg_err_resp_en | input | 1 | Blocked accesses answer with error |
| irq_clr | input | 1 | Clears and suppresses the violation flag |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | 32 | Byte address |
| up_req_size | input | 2 | Size code, 2^k bytes |
| up_req_wdata | input | 64 | Write data, right-justified |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_rdata | output | 64 | Read data, right-justified |
| up_rsp_err | output | 1 | Error status |
| chk_exempt | input | 1 | Region checker: address exempt |
| chk_nonsec | input | 1 | Region checker: non-secure region |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | Downstream write |
| dn_req_addr | output | 32 | Downstream address |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_be | output | 8 | Byte lane enables |
| dn_req_wdata | output | 64 | Lane-aligned write data |
| dn_req_secure | output | 1 | Security attribute |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | 64 | Lane-aligned read data |
| dn_rsp_err | input | 1 | Downstream error status |
| irq | output | 1 | Violation interrupt, level |

## Verification
A wrong verdict shows at the ports one cycle after acceptance. The signs are a dn_req_valid that should have stayed low, the wrong dn_req_secure value, or a local response that should not have arrived. A corrupt violation flag shows on irq in that same cycle, or stays visible until interrupt-clear removes it two cycles after it is raised. A fault in the handshake state shows as up_req_ready rising before the response is returned, or as a downstream request that drops before dn_req_ready. Lane steering errors appear in the dn_req_be and dn_req_wdata of the same cycle, and in the response data one cycle after the downstream reply.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;
  typedef enum logic [1:0] {
    VERDICT_ERR    = 2'd0,
    VERDICT_RAZWI  = 2'd1,
    VERDICT_FWD_S  = 2'd2,
    VERDICT_FWD_NS = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } fsm_e;
endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/sec_verdict.sv
module sec_verdict
  import sec_filter_pkg::*;
(
  input  logic     exempt,
  input  logic     nonsec,
  input  logic     master_ns,
  input  logic     err_en,
  output verdict_e verdict
);
  always_comb begin
    if (exempt)          verdict = master_ns ? VERDICT_FWD_NS : VERDICT_FWD_S;
    else if (nonsec)     verdict = VERDICT_FWD_NS;
    else if (!master_ns) verdict = VERDICT_FWD_S;
    else if (err_en)     verdict = VERDICT_ERR;
    else                 verdict = VERDICT_RAZWI;
  end
endmodule

// File: rtl/sec_lane_steer.sv
module sec_lane_steer #(
  parameter int NB    = 8,
  parameter int OFS_W = $clog2(NB),
  parameter int SZ_W  = $clog2(OFS_W + 1),
  parameter int DW    = 8 * NB
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [SZ_W-1:0]  size,
  input  logic [DW-1:0]    wdata_in,
  input  logic [DW-1:0]    rdata_in,
  output logic [NB-1:0]    be,
  output logic [DW-1:0]    wdata_out,
  output logic [DW-1:0]    rdata_out
);
  localparam int CW = OFS_W + 2;

  logic [CW-1:0] nbytes;
  logic [CW-1:0] ofs_ext;
  logic [CW-1:0] end_ext;
  logic [NB-1:0] keep;
  logic [DW-1:0] wkeep;
  logic [DW-1:0] rshift;

  assign nbytes   = CW'(1) << size;
  assign ofs_ext  = CW'(ofs);
  assign end_ext  = ofs_ext + nbytes;
  assign rshift   = rdata_in >> {ofs, 3'b000};
  assign wdata_out = wkeep << {ofs, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [CW-1:0] IDX = CW'(i);
    assign keep[i]            = IDX < nbytes;
    assign be[i]              = (IDX >= ofs_ext) && (IDX < end_ext);
    assign wkeep[8*i +: 8]    = keep[i] ? wdata_in[8*i +: 8] : 8'h00;
    assign rdata_out[8*i +: 8] = keep[i] ? rshift[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/sec_irq_status.sv
module sec_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic status
);
  logic status_d;
  logic status_q;

  always_comb begin
    if (clr)      status_d = 1'b0;
    else if (set) status_d = 1'b1;
    else          status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status = status_q;
endmodule

// File: rtl/bus_sec_filter.sv
module bus_sec_filter
  import sec_filter_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = 8,
  localparam int OFS_W = $clog2(NB),
  localparam int SZ_W  = $clog2(OFS_W + 1),
  localparam int DW    = 8 * NB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master_ns,
  input  logic             cfg_err_resp_en,
  input  logic             irq_clr,
  input  logic             up_req_valid,
  output logic             up_req_ready,
  input  logic             up_req_write,
  input  logic [AW-1:0]    up_req_addr,
  input  logic [SZ_W-1:0]  up_req_size,
  input  logic [DW-1:0]    up_req_wdata,
  output logic             up_rsp_valid,
  output logic [DW-1:0]    up_rsp_rdata,
  output logic             up_rsp_err,
  input  logic             chk_exempt,
  input  logic             chk_nonsec,
  output logic             dn_req_valid,
  input  logic             dn_req_ready,
  output logic             dn_req_write,
  output logic [AW-1:0]    dn_req_addr,
  output logic [SZ_W-1:0]  dn_req_size,
  output logic [NB-1:0]    dn_req_be,
  output logic [DW-1:0]    dn_req_wdata,
  output logic             dn_req_secure,
  input  logic             dn_rsp_valid,
  input  logic [DW-1:0]    dn_rsp_rdata,
  input  logic             dn_rsp_err,
  output logic             irq
);
  logic rst_ns;

  sec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // configuration levels, captured every cycle
  logic cfg_ns_q, cfg_err_q, cfg_clr_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_ns_q  <= 1'b0;
      cfg_err_q <= 1'b0;
      cfg_clr_q <= 1'b0;
    end else begin
      cfg_ns_q  <= cfg_master_ns;
      cfg_err_q <= cfg_err_resp_en;
      cfg_clr_q <= irq_clr;
    end
  end

  verdict_e verdict;
  sec_verdict u_verdict (
    .exempt   (chk_exempt),
    .nonsec   (chk_nonsec),
    .master_ns(cfg_ns_q),
    .err_en   (cfg_err_q),
    .verdict  (verdict)
  );

  fsm_e state_q, state_d;
  logic accept;
  logic blocked;
  logic req_cap_en;
  logic rsp_cap_en;

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept       = up_req_valid && up_req_ready;
  assign blocked      = (verdict == VERDICT_ERR) || (verdict == VERDICT_RAZWI);
  assign req_cap_en   = accept;
  assign rsp_cap_en   = accept || ((state_q == ST_WAIT) && dn_rsp_valid);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = blocked ? ST_RESP : ST_ISSUE;
      ST_ISSUE: if (dn_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (dn_rsp_valid) state_d = ST_RESP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // captured request
  logic             req_write_q;
  logic [AW-1:0]    req_addr_q;
  logic [SZ_W-1:0]  req_size_q;
  logic [DW-1:0]    req_wdata_q;
  logic             req_secure_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      req_write_q  <= 1'b0;
      req_addr_q   <= '0;
      req_size_q   <= '0;
      req_wdata_q  <= '0;
      req_secure_q <= 1'b0;
    end else if (req_cap_en) begin
      req_write_q  <= up_req_write;
      req_addr_q   <= up_req_addr;
      req_size_q   <= up_req_size;
      req_wdata_q  <= up_req_wdata;
      req_secure_q <= (verdict == VERDICT_FWD_S);
    end
  end

  logic [DW-1:0] rd_steered;
  sec_lane_steer #(.NB(NB), .OFS_W(OFS_W), .SZ_W(SZ_W), .DW(DW)) u_steer (
    .ofs      (req_addr_q[OFS_W-1:0]),
    .size     (req_size_q),
    .wdata_in (req_wdata_q),
    .rdata_in (dn_rsp_rdata),
    .be       (dn_req_be),
    .wdata_out(dn_req_wdata),
    .rdata_out(rd_steered)
  );

  // response registers
  logic [DW-1:0] rsp_rdata_d, rsp_rdata_q;
  logic          rsp_err_d,   rsp_err_q;

  always_comb begin
    if (accept) begin
      rsp_rdata_d = '0;
      rsp_err_d   = (verdict == VERDICT_ERR);
    end else begin
      rsp_rdata_d = rd_steered;
      rsp_err_d   = dn_rsp_err;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else if (rsp_cap_en) begin
      rsp_rdata_q <= rsp_rdata_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  sec_irq_status u_irq (
    .clk   (clk),
    .rst_n (rst_ns),
    .set   (accept && (verdict == VERDICT_ERR)),
    .clr   (cfg_clr_q),
    .status(irq)
  );

  assign dn_req_valid  = (state_q == ST_ISSUE);
  assign dn_req_write  = req_write_q;
  assign dn_req_addr   = req_addr_q;
  assign dn_req_size   = req_size_q;
  assign dn_req_secure = req_secure_q;
  assign up_rsp_valid  = (state_q == ST_RESP);
  assign up_rsp_rdata  = rsp_rdata_q;
  assign up_rsp_err    = rsp_err_q;
endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_req_valid,
  input logic          up_req_ready,
  input logic          chk_exempt,
  input logic          chk_nonsec,
  input logic          ns_q,
  input logic          err_q,
  input logic          clr_q,
  input logic          dn_req_valid,
  input logic          dn_req_ready,
  input logic [AW-1:0] dn_req_addr,
  input logic          dn_req_secure,
  input logic          up_rsp_valid,
  input logic          up_rsp_err,
  input logic          irq
);
  logic acc;
  logic sec_region;
  assign acc        = up_req_valid && up_req_ready;
  assign sec_region = !chk_exempt && !chk_nonsec;

  assert_exempt_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && chk_exempt |=> dn_req_valid && (dn_req_secure == !$past(ns_q)));

  assert_ns_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !chk_exempt && chk_nonsec |=> dn_req_valid && !dn_req_secure);

  assert_sec_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_region && !ns_q |=> dn_req_valid && dn_req_secure);

  assert_block_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_region && ns_q |=> !dn_req_valid && up_rsp_valid);

  assert_err_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_region && ns_q && err_q |=> up_rsp_err);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !irq);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !up_req_ready);

  assert_dn_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr));
endmodule

bind bus_sec_filter sec_filter_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_ns),
  .up_req_valid (up_req_valid),
  .up_req_ready (up_req_ready),
  .chk_exempt   (chk_exempt),
  .chk_nonsec   (chk_nonsec),
  .ns_q         (cfg_ns_q),
  .err_q        (cfg_err_q),
  .clr_q        (cfg_clr_q),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_addr  (dn_req_addr),
  .dn_req_secure(dn_req_secure),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_err   (up_rsp_err),
  .irq          (irq)
);

// File: tb/bus_sec_filter_test.sv
module bus_sec_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_master_ns, cfg_err_resp_en, irq_clr;
  logic        up_req_valid, up_req_ready, up_req_write;
  logic [31:0] up_req_addr;
  logic [1:0]  up_req_size;
  logic [63:0] up_req_wdata;
  logic        up_rsp_valid;
  logic [63:0] up_rsp_rdata;
  logic        up_rsp_err;
  logic        chk_exempt, chk_nonsec;
  logic        dn_req_valid, dn_req_ready, dn_req_write;
  logic [31:0] dn_req_addr;
  logic [1:0]  dn_req_size;
  logic [7:0]  dn_req_be;
  logic [63:0] dn_req_wdata;
  logic        dn_req_secure;
  logic        dn_rsp_valid;
  logic [63:0] dn_rsp_rdata;
  logic        dn_rsp_err;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int dn_seen = 0;

  always #4 clk = ~clk;

  bus_sec_filter uut (.*);

  always @(posedge clk) if (dn_req_valid) dn_seen++;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic set_cfg(input logic ns, input logic err, input logic clr);
    @(negedge clk);
    cfg_master_ns = ns; cfg_err_resp_en = err; irq_clr = clr;
    @(negedge clk);
    @(negedge clk);
  endtask

  // allowed access with a stalled downstream accept
  task automatic fwd_access(input string req, input logic w, input logic [31:0] a,
                            input logic [1:0] sz, input logic [63:0] wd,
                            input logic ex, input logic ns, input logic exp_sec,
                            input logic [7:0] exp_be, input logic [63:0] exp_wd,
                            input logic [63:0] rd, input logic rerr, input logic [63:0] exp_rd);
    @(negedge clk);
    eq({req, " R11 ready idle"}, up_req_ready, 1'b1);
    up_req_valid = 1'b1; up_req_write = w; up_req_addr = a; up_req_size = sz;
    up_req_wdata = wd; chk_exempt = ex; chk_nonsec = ns;
    @(negedge clk);
    up_req_valid = 1'b0; chk_exempt = 1'b0; chk_nonsec = 1'b0;
    eq({req, " R12 dn valid"}, dn_req_valid, 1'b1);
    eq({req, " secure attr"}, dn_req_secure, exp_sec);
    eq({req, " R9 addr"}, dn_req_addr, a);
    eq({req, " R9 be"}, dn_req_be, exp_be);
    if (w) eq({req, " R9 wdata"}, dn_req_wdata, exp_wd);
    eq({req, " R11 ready busy"}, up_req_ready, 1'b0);
    @(negedge clk);
    eq({req, " R11 dn hold"}, {dn_req_valid, dn_req_addr}, {1'b1, a});
    dn_req_ready = 1'b1;
    @(negedge clk);
    dn_req_ready = 1'b0;
    eq({req, " R11 dn drop"}, dn_req_valid, 1'b0);
    dn_rsp_valid = 1'b1; dn_rsp_rdata = rd; dn_rsp_err = rerr;
    @(negedge clk);
    dn_rsp_valid = 1'b0;
    eq({req, " R12 rsp valid"}, up_rsp_valid, 1'b1);
    eq({req, " R10 rsp err"}, up_rsp_err, rerr);
    if (!w) eq({req, " R10 rdata"}, up_rsp_rdata, exp_rd);
    @(negedge clk);
    eq({req, " R12 rsp pulse"}, {up_rsp_valid, up_req_ready}, 2'b01);
  endtask

  task automatic blk_access(input string req, input logic w, input logic exp_err, input logic exp_irq);
    int seen0;
    @(negedge clk);
    seen0 = dn_seen;
    up_req_valid = 1'b1; up_req_write = w; up_req_addr = 32'h100;
    up_req_size = 2'd3; up_req_wdata = 64'hDEAD_BEEF_0123_4567;
    chk_exempt = 1'b0; chk_nonsec = 1'b0;
    @(negedge clk);
    up_req_valid = 1'b0;
    eq({req, " R4 local rsp"}, {up_rsp_valid, dn_req_valid}, 2'b10);
    eq({req, " rsp err"}, up_rsp_err, exp_err);
    if (!w) eq({req, " R5 zero data"}, up_rsp_rdata, 64'h0);
    eq({req, " irq"}, irq, exp_irq);
    @(negedge clk);
    eq({req, " R4 never downstream"}, dn_seen, seen0);
    eq({req, " R4 ready again"}, up_req_ready, 1'b1);
  endtask

  task automatic t_reset;
    eq("R8 irq", irq, 1'b0);
    eq("R8 ready", up_req_ready, 1'b1);
    eq("R8 dn valid", dn_req_valid, 1'b0);
    eq("R8 rsp valid", up_rsp_valid, 1'b0);
    // master secure after reset: secure region forwarded secure (R8, R3)
    fwd_access("R8 R3 secure master", 1'b0, 32'h40, 2'd3, 64'h0, 1'b0, 1'b0, 1'b1,
               8'hFF, 64'h0, 64'h1122_3344_5566_7788, 1'b0, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_exempt;
    set_cfg(1'b0, 1'b0, 1'b0);
    fwd_access("R1 exempt secure", 1'b0, 32'h8, 2'd2, 64'h0, 1'b1, 1'b0, 1'b1,
               8'h0F, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 64'hCCCC_DDDD);
    set_cfg(1'b1, 1'b0, 1'b0);
    fwd_access("R1 exempt nonsec", 1'b0, 32'h8, 2'd2, 64'h0, 1'b1, 1'b0, 1'b0,
               8'h0F, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 64'hCCCC_DDDD);
  endtask

  task automatic t_ns_region;
    set_cfg(1'b0, 1'b1, 1'b0);
    fwd_access("R2 ns region secure master", 1'b1, 32'h10, 2'd3, 64'h0102_0304_0506_0708,
               1'b0, 1'b1, 1'b0, 8'hFF, 64'h0102_0304_0506_0708, 64'h0, 1'b0, 64'h0);
    set_cfg(1'b1, 1'b1, 1'b0);
    fwd_access("R2 ns region ns master", 1'b0, 32'h10, 2'd3, 64'h0, 1'b0, 1'b1, 1'b0,
               8'hFF, 64'h0, 64'h55, 1'b1, 64'h55);
  endtask

  task automatic t_block_razwi;
    set_cfg(1'b1, 1'b0, 1'b0);
    blk_access("R5 razwi read", 1'b0, 1'b0, 1'b0);
    blk_access("R5 razwi write", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_irq;
    set_cfg(1'b1, 1'b1, 1'b0);
    blk_access("R6 err read", 1'b0, 1'b1, 1'b1);
    fwd_access("R7 sticky", 1'b0, 32'h0, 2'd0, 64'h0, 1'b0, 1'b1, 1'b0,
               8'h01, 64'h0, 64'h77, 1'b0, 64'h77);
    eq("R7 sticky irq", irq, 1'b1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    eq("R7 one cycle after clr", irq, 1'b1);
    @(negedge clk);
    eq("R7 cleared", irq, 1'b0);
    blk_access("R6 suppressed", 1'b1, 1'b1, 1'b0);
    set_cfg(1'b1, 1'b1, 1'b0);
    eq("R6 stays low after release", irq, 1'b0);
  endtask

  task automatic t_lanes;
    set_cfg(1'b0, 1'b0, 1'b0);
    fwd_access("R9 half write ofs6", 1'b1, 32'h206, 2'd1, 64'hFFFF_FFFF_FFFF_BEEF,
               1'b0, 1'b0, 1'b1, 8'hC0, 64'hBEEF_0000_0000_0000, 64'h0, 1'b0, 64'h0);
    fwd_access("R9 byte write ofs3", 1'b1, 32'h203, 2'd0, 64'h0000_0000_0000_12A5,
               1'b0, 1'b0, 1'b1, 8'h08, 64'h0000_0000_A500_0000, 64'h0, 1'b0, 64'h0);
    fwd_access("R10 half read ofs2", 1'b0, 32'h302, 2'd1, 64'h0, 1'b0, 1'b0, 1'b1,
               8'h0C, 64'h0, 64'h8877_6655_4433_2211, 1'b0, 64'h4433);
    fwd_access("R10 byte read ofs7", 1'b0, 32'h307, 2'd0, 64'h0, 1'b0, 1'b0, 1'b1,
               8'h80, 64'h0, 64'h8877_6655_4433_2211, 1'b0, 64'h88);
    fwd_access("R10 word read ofs4", 1'b0, 32'h304, 2'd2, 64'h0, 1'b0, 1'b0, 1'b1,
               8'hF0, 64'h0, 64'h8877_6655_4433_2211, 1'b1, 64'h8877_6655);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_master_ns = 1'b0; cfg_err_resp_en = 1'b0; irq_clr = 1'b0;
    up_req_valid = 1'b0; up_req_write = 1'b0; up_req_addr = '0; up_req_size = '0;
    up_req_wdata = '0; chk_exempt = 1'b0; chk_nonsec = 1'b0;
    dn_req_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_rdata = '0; dn_rsp_err = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exempt();
    t_ns_region();
    t_block_razwi();
    t_irq();
    t_lanes();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule